// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two 8-bit operands using one full adder and one carry flip-flop. It handles a single bit position per clock. Each operand sits in its own register, and both registers shift right, so the least significant bits meet first. Each sum bit enters the top of the first operand register. The second operand register feeds its own low bit back into its top bit, so after a full pass it holds its original value again. When the run ends, the first register holds the sum and the second register holds the operand it started with. The carry out of the top bit stays in the carry flip-flop as the overflow of the addition.

A hardwired controller sits in idle until it sees a start request. It then clears the carry flip-flop and the bit counter and selects the addition paths of both input multiplexers. After that it shifts and counts once per cycle until the counter shows that every bit position has been added. A parallel load strobe writes both registers from outside, but only while no addition is running. A new start without a reload adds the second operand again to the previous sum.

Top module: `bit_serial_adder`

## Requirements
- R1: After a synchronous active-low reset, both operand registers read zero, the carry output reads 0, and busy and done are low.
- R2: While busy is low, a high load strobe writes the load inputs into both operand registers at the next clock edge.
- R3: A load strobe asserted while busy is high changes neither register and does not change the result.
- R4: The run that follows an accepted start leaves (A + B) mod 2^WIDTH in the first register. The low bit is added first.
- R5: When done is high, the second register holds the operand value it had when the run began.
- R6: When done is high, the carry output equals bit WIDTH of the full sum A + B. It stays unchanged until the next accepted start, and a load does not change it.
- R7: Busy rises at the clock edge that accepts a start and stays high for exactly WIDTH cycles.
- R8: Done is high for exactly one cycle, the cycle right after busy falls. Busy is low in that cycle.
- R9: A start request while busy is high is ignored. The run still ends after WIDTH cycles with the same result.
- R10: Each accepted start clears the carry first, so a carry left by the previous run never enters the next sum.
- R11: A start with no reload adds the kept second operand to the sum that the first register already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| loadEn | input | 1 | Parallel load strobe, accepted only while idle |
| loadA | input | WIDTH | Value to load into the first operand register |
| loadB | input | WIDTH | Value to load into the second operand register |
| start | input | 1 | Begins an addition when idle |
| busy | output | 1 | High while bit additions are running |
| done | output | 1 | One-cycle pulse when the sum is valid |
| carryOut | output | 1 | Carry flip-flop, overflow of the last sum |
| regA | output | WIDTH | First operand register, holds the sum after a run |
| regB | output | WIDTH | Second operand register |

## Verification
The bench targets carry behaviour at the edges. It adds all-ones to one, which ripples a carry through every bit. If the carry were not cleared at the next start, a follow-on run would be one too high. It also sends load and start requests in the middle of a run. A design that honoured them would corrupt the sum or stretch busy past WIDTH cycles. The bench checks the second operand after each run, because feeding a zero or the sum back into it would lose the operand. It also checks that the overflow bit survives idle cycles and loads, since a design that cleared it on load would lose it.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } addState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic shiftA;    // update register A this cycle
    logic shiftB;    // update register B this cycle
    logic selA;      // 1: parallel load path, 0: adder sum into MSB
    logic selB;      // 1: parallel load path, 0: own LSB into MSB
    logic clrCarry;  // clear carry flip-flop
    logic clrCount;  // clear bit counter
    logic incCount;  // advance bit counter
  } ctlStrobes_t;

endpackage

// File: rtl/serial_add_datapath.sv
module serial_add_datapath
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [WIDTH-1:0] loadA,
  input  logic [WIDTH-1:0] loadB,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB,
  output logic             carryOut,
  output logic             lastBit
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] aReg, bReg;
  logic             carryQ;
  logic [CW-1:0]    bitCount;
  logic             sumBit, carryNext;
  logic [WIDTH-1:0] aNext, bNext;

  // single full adder on the two low bits
  always_comb begin
    sumBit    = aReg[0] ^ bReg[0] ^ carryQ;
    carryNext = (aReg[0] & bReg[0]) | (aReg[0] & carryQ) | (bReg[0] & carryQ);
  end

  // input multiplexers
  always_comb begin
    aNext = ctl.selA ? loadA : {sumBit, aReg[WIDTH-1:1]};
    bNext = ctl.selB ? loadB : {bReg[0], bReg[WIDTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      carryQ   <= 1'b0;
      bitCount <= '0;
    end else begin
      if (ctl.shiftA) aReg <= aNext;
      if (ctl.shiftB) bReg <= bNext;
      if (ctl.clrCarry)
        carryQ <= 1'b0;
      else if (ctl.shiftA && !ctl.selA)
        carryQ <= carryNext;
      if (ctl.clrCount)
        bitCount <= '0;
      else if (ctl.incCount)
        bitCount <= bitCount + 1'b1;
    end
  end

  assign regA     = aReg;
  assign regB     = bReg;
  assign carryOut = carryQ;
  assign lastBit  = (bitCount == LAST);

endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
  import serial_add_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        loadEn,
  input  logic        lastBit,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);

  addState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_RUN: begin
        ctl.shiftA   = 1'b1;
        ctl.shiftB   = 1'b1;
        ctl.selA     = 1'b0;
        ctl.selB     = 1'b0;
        ctl.incCount = 1'b1;
        if (lastBit) nextState = ST_FIN;
      end
      default: begin
        // idle or finishing: loads allowed, start accepted
        ctl.shiftA   = loadEn;
        ctl.shiftB   = loadEn;
        ctl.selA     = 1'b1;
        ctl.selB     = 1'b1;
        ctl.clrCarry = start;
        ctl.clrCount = start;
        nextState    = start ? ST_RUN : ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadA,
  input  logic [WIDTH-1:0] loadB,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             carryOut,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB
);

  ctlStrobes_t ctl;
  logic        lastBit;

  serial_add_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .loadEn  (loadEn),
    .lastBit (lastBit),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  serial_add_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadA    (loadA),
    .loadB    (loadB),
    .regA     (regA),
    .regB     (regB),
    .carryOut (carryOut),
    .lastBit  (lastBit)
  );

endmodule

// File: rtl/serial_add_chk.sv
module serial_add_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             carryOut,
  input logic [WIDTH-1:0] regB
);

  localparam int LW = $clog2(WIDTH + 2);

  logic [LW-1:0]    busyLen;
  logic             wasBusy;
  logic [WIDTH-1:0] savedB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen <= '0;
      wasBusy <= 1'b0;
      savedB  <= '0;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      wasBusy <= busy;
      if (busy && !wasBusy) savedB <= regB;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyLen == LW'(WIDTH)));

  // R5
  b_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (regB == savedB));

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(carryOut));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (busyLen < LW'(WIDTH - 1))) |=> busy);

endmodule

bind bit_serial_adder serial_add_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .carryOut (carryOut),
  .regB     (regB)
);

// File: tb/bit_serial_adder_test.sv
module bit_serial_adder_test;

  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;

  // {a, b}; expected values computed below
  localparam logic [2*WIDTH-1:0] VECS [NVEC] = '{
    {8'h00, 8'h00}, {8'h01, 8'h01}, {8'h0F, 8'h01}, {8'hFF, 8'h01},
    {8'hAA, 8'h55}, {8'h80, 8'h80}, {8'h3C, 8'hC4}, {8'h7E, 8'h13}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [WIDTH-1:0] loadA = '0, loadB = '0;
  logic start = 1'b0;
  logic busy, done, carryOut;
  logic [WIDTH-1:0] regA, regB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_serial_adder #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadA(loadA), .loadB(loadB),
    .start(start), .busy(busy), .done(done), .carryOut(carryOut),
    .regA(regA), .regB(regB)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one run; optional load first; optional disturbance mid-run
  task automatic runAdd(input bit doLoad, input logic [WIDTH-1:0] a,
                        input logic [WIDTH-1:0] b, input bit disturb);
    logic [WIDTH:0] full;
    int busyCnt;
    full = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    loadEn = doLoad; loadA = a; loadB = b; start = 1'b1;
    @(negedge clk);
    loadEn = 1'b0; start = 1'b0;
    busyCnt = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (busy) busyCnt++;
      if (disturb && i == 3) begin
        loadEn = 1'b1; loadA = 8'h5A; loadB = 8'hC3; start = 1'b1;
      end
      @(negedge clk);
      loadEn = 1'b0; start = 1'b0;
    end
    check(busyCnt == WIDTH && !busy, "R7 busy length", busyCnt, WIDTH);
    check(done == 1'b1, "R8 done pulse", int'(done), 1);
    check(regA == full[WIDTH-1:0], disturb ? "R3/R9 sum with disturbance" : "R4 sum",
          int'(regA), int'(full[WIDTH-1:0]));
    check(regB == b, "R5 operand kept", int'(regB), int'(b));
    check(carryOut == full[WIDTH], "R6 carry out", int'(carryOut), int'(full[WIDTH]));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] va, vb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(regA == 0 && regB == 0, "R1 regs zero", int'({regA, regB}), 0);
    check(!busy && !done && !carryOut, "R1 flags low",
          int'({busy, done, carryOut}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 load while idle
    loadEn = 1'b1; loadA = 8'h12; loadB = 8'h34;
    @(negedge clk);
    loadEn = 1'b0;
    check(regA == 8'h12 && regB == 8'h34, "R2 idle load",
          int'({regA, regB}), 16'h1234);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      va = VECS[k][2*WIDTH-1:WIDTH];
      vb = VECS[k][WIDTH-1:0];
      runAdd(1'b1, va, vb, 1'b0);
    end

    // R10: previous run (FF+01) left carry=1; add without reload: 00+01 = 01
    runAdd(1'b1, 8'hFF, 8'h01, 1'b0);
    runAdd(1'b0, 8'h00, 8'h01, 1'b0);
    check(regA == 8'h01, "R10 carry cleared at start", int'(regA), 1);

    // R11 accumulate with kept B
    runAdd(1'b1, 8'h10, 8'h07, 1'b0);
    runAdd(1'b0, 8'h17, 8'h07, 1'b0);
    check(regA == 8'h1E, "R11 accumulate", int'(regA), 8'h1E);

    // R3 and R9: load and start during run ignored
    runAdd(1'b1, 8'h21, 8'h42, 1'b1);
    check(!busy && regA == 8'h63, "R9 no extra run", int'(busy), 0);

    // R6 carry held through idle and a load
    runAdd(1'b1, 8'hC0, 8'h40, 1'b0);
    loadEn = 1'b1; loadA = 8'h01; loadB = 8'h02;
    @(negedge clk);
    loadEn = 1'b0;
    repeat (3) @(negedge clk);
    check(carryOut == 1'b1, "R6 carry held after load", int'(carryOut), 1);

    // R1 reset mid-run
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(!busy && regA == 0 && regB == 0 && !carryOut, "R1 reset mid-run",
          int'({busy, regA, regB}), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule